// File: doc/BRIEF.md
# Auto-Repeat Shift and Drop Controller

This block converts held button levels for a falling-block game into movement commands. It receives the debounced levels of four buttons: shift left, shift right, soft drop and hard drop. It also receives a frame tick, which arrives sixty times a second. From these it issues single-cycle command pulses. A horizontal button that is held gives one move at once. After a programmable charge delay it repeats at a programmable frame interval. A held soft-drop button steps the piece down on its own frame interval. A hard-drop press gives a single command. After a new-piece strobe, hard-drop presses are locked out for a programmable number of frames. This stops a press meant for the previous piece from dropping the new one by accident.

When both horizontal buttons are held, the one pressed most recently decides the direction. If that button is released while the other is still down, control passes back to the other button and its charge delay starts again. All four frame counts are inputs, so software or a menu can change them while the game runs.

The command outputs are plain pulses with no back-pressure. A consumer that cannot act on a pulse in the cycle it appears loses that command. The configuration inputs are plain levels and are sampled on every frame tick.

Top module: `autoshift_ctrl`

## Requirements
- R1: While `rst_n` is low, all four command outputs are 0. After reset, every button counts as released at the previous frame, so a button held through reset gives a fresh press on the first frame tick.
- R2: State advances only in cycles where `frame_tick` is 1. Each command is a pulse one cycle wide, in the cycle that follows the frame tick.
- R3: A horizontal button is freshly pressed when its level is 1 at a frame tick and was 0 at the previous frame tick. A fresh press gives one move in that direction on that frame.
- R4: While the active horizontal button stays held, the first repeat move comes `das_frames` ticks after the press. Further moves come every `arr_frames` ticks after that. A count of 0 behaves as 1, so `arr_frames` = 0 gives a move on every tick.
- R5: The most recent fresh press sets the direction. If both buttons are freshly pressed on the same tick, left wins. `move_left` and `move_right` are never 1 together.
- R6: When the active button is released and the opposite button is still held, the opposite button becomes active. Its charge delay is reloaded and no move is issued on that tick; its first move comes `das_frames` ticks later.
- R7: A fresh soft-drop press gives one step at once. While the button stays held, a step follows every `sdf_frames` ticks (0 behaves as 1). Soft drop and horizontal moves work independently and may pulse on the same cycle.
- R8: A fresh hard-drop press gives one `hard_drop` pulse. Holding the button gives no further pulses.
- R9: A `piece_spawn` strobe loads a guard of `dcd_frames` ticks. A fresh hard-drop press on any of those ticks is discarded and is not deferred. If `dcd_frames` = 0 there is no guard. A strobe on a tick cycle counts that tick as the first guarded tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe per game frame |
| key_left | input | 1 | Shift-left button level |
| key_right | input | 1 | Shift-right button level |
| key_soft | input | 1 | Soft-drop button level |
| key_hard | input | 1 | Hard-drop button level |
| piece_spawn | input | 1 | One-cycle strobe when a new piece appears |
| das_frames | input | W | Charge delay in frames before horizontal repeat |
| arr_frames | input | W | Horizontal repeat interval in frames |
| sdf_frames | input | W | Soft-drop step interval in frames |
| dcd_frames | input | W | Hard-drop guard length in frames |
| move_left | output | 1 | Shift-left command pulse |
| move_right | output | 1 | Shift-right command pulse |
| soft_step | output | 1 | Soft-drop step pulse |
| hard_drop | output | 1 | Hard-drop command pulse |

## Verification
The bench keeps the default 8-bit counter width. It drives the timing inputs with small values: a charge delay of 3, a repeat interval of 2, a soft-drop interval of 2 and a guard of 2. With these values the charge, the steady repeat, the direction handover and the guard expiry each fit into a few frames of the vector table. A second phase sets the charge delay to 1 and the repeat interval to 0, which checks the every-frame repeat. A third phase sets the guard to 0, so that a hard drop straight after a spawn must go through.

// File: rtl/autoshift_pkg.sv
package autoshift_pkg;
  typedef enum logic [1:0] {
    HDIR_NONE  = 2'd0,
    HDIR_LEFT  = 2'd1,
    HDIR_RIGHT = 2'd2
  } hdir_e;
endpackage

// File: rtl/autoshift_repeater.sv
// Frame-counted repeat timer: a restart loads the first interval, then each
// expiry fires and reloads the steady interval. Counts of 0 or 1 fire every tick.
module autoshift_repeater #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] first_len,
  input  logic [W-1:0] period,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic         due;

  assign due  = (cnt_q <= W'(1));
  assign fire = tick && !restart && run && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (restart) begin
        cnt_q <= first_len;
      end else if (run) begin
        if (due) cnt_q <= period;
        else     cnt_q <= cnt_q - W'(1);
      end
    end
  end
endmodule

// File: rtl/autoshift_arbiter.sv
// Horizontal direction arbiter: last fresh press wins, left on a tie,
// handover to the opposite held key when the active one is released.
module autoshift_arbiter
  import autoshift_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  lvl_l,
  input  logic  lvl_r,
  input  logic  prev_l,
  input  logic  prev_r,
  output hdir_e dir_nxt,
  output logic  fresh,
  output logic  handover
);
  hdir_e dir_q;
  logic  edge_l, edge_r;

  assign edge_l = lvl_l && !prev_l;
  assign edge_r = lvl_r && !prev_r;

  always_comb begin
    dir_nxt  = dir_q;
    fresh    = 1'b0;
    handover = 1'b0;
    if (edge_l) begin
      dir_nxt = HDIR_LEFT;
      fresh   = 1'b1;
    end else if (edge_r) begin
      dir_nxt = HDIR_RIGHT;
      fresh   = 1'b1;
    end else begin
      case (dir_q)
        HDIR_LEFT: if (!lvl_l) begin
          if (lvl_r) begin
            dir_nxt  = HDIR_RIGHT;
            handover = 1'b1;
          end else begin
            dir_nxt = HDIR_NONE;
          end
        end
        HDIR_RIGHT: if (!lvl_r) begin
          if (lvl_l) begin
            dir_nxt  = HDIR_LEFT;
            handover = 1'b1;
          end else begin
            dir_nxt = HDIR_NONE;
          end
        end
        default: dir_nxt = HDIR_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_q <= HDIR_NONE;
    else if (tick) dir_q <= dir_nxt;
  end
endmodule

// File: rtl/autoshift_drop_guard.sv
// Hard-drop guard: a spawn strobe opens a window of a programmable number of
// frame ticks during which hard-drop presses are discarded.
module autoshift_drop_guard #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         spawn,
  input  logic [W-1:0] guard_len,
  output logic         allow
);
  logic [W-1:0] cnt_q;
  logic         len_nz;

  assign len_nz = (guard_len != '0);
  assign allow  = spawn ? !len_nz : (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (spawn) begin
      cnt_q <= (tick && len_nz) ? guard_len - W'(1) : guard_len;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/autoshift_ctrl.sv
module autoshift_ctrl
  import autoshift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_tick,
  input  logic         key_left,
  input  logic         key_right,
  input  logic         key_soft,
  input  logic         key_hard,
  input  logic         piece_spawn,
  input  logic [W-1:0] das_frames,
  input  logic [W-1:0] arr_frames,
  input  logic [W-1:0] sdf_frames,
  input  logic [W-1:0] dcd_frames,
  output logic         move_left,
  output logic         move_right,
  output logic         soft_step,
  output logic         hard_drop
);
  localparam int NKEY = 4;

  logic [NKEY-1:0] lvl, prev_q;
  logic            edge_s, edge_h;
  hdir_e           dir_nxt;
  logic            h_fresh, h_handover, h_fire, h_run;
  logic            s_fire, hard_ok, h_move;

  assign lvl    = {key_hard, key_soft, key_right, key_left};
  assign edge_s = key_soft && !prev_q[2];
  assign edge_h = key_hard && !prev_q[3];

  // Previous-frame levels, captured on every frame tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prev_q <= '0;
    else if (frame_tick) prev_q <= lvl;
  end

  autoshift_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frame_tick),
    .lvl_l    (key_left),
    .lvl_r    (key_right),
    .prev_l   (prev_q[0]),
    .prev_r   (prev_q[1]),
    .dir_nxt  (dir_nxt),
    .fresh    (h_fresh),
    .handover (h_handover)
  );

  assign h_run = (dir_nxt != HDIR_NONE);

  autoshift_repeater #(.W(W)) u_hrep (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (frame_tick),
    .restart   (h_fresh || h_handover),
    .run       (h_run),
    .first_len (das_frames),
    .period    (arr_frames),
    .fire      (h_fire)
  );

  autoshift_repeater #(.W(W)) u_srep (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (frame_tick),
    .restart   (edge_s),
    .run       (key_soft),
    .first_len (sdf_frames),
    .period    (sdf_frames),
    .fire      (s_fire)
  );

  autoshift_drop_guard #(.W(W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (frame_tick),
    .spawn     (piece_spawn),
    .guard_len (dcd_frames),
    .allow     (hard_ok)
  );

  assign h_move = frame_tick && (h_fresh || h_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      move_left  <= 1'b0;
      move_right <= 1'b0;
      soft_step  <= 1'b0;
      hard_drop  <= 1'b0;
    end else begin
      move_left  <= h_move && (dir_nxt == HDIR_LEFT);
      move_right <= h_move && (dir_nxt == HDIR_RIGHT);
      soft_step  <= frame_tick && (edge_s || s_fire);
      hard_drop  <= frame_tick && edge_h && hard_ok;
    end
  end
endmodule

// File: rtl/autoshift_ctrl_chk.sv
module autoshift_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_tick,
  input logic         key_left,
  input logic         key_right,
  input logic         key_soft,
  input logic         key_hard,
  input logic         piece_spawn,
  input logic [W-1:0] dcd_frames,
  input logic         move_left,
  input logic         move_right,
  input logic         soft_step,
  input logic         hard_drop
);
  // R5
  no_dual_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(move_left && move_right));

  // R2
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_left || move_right || soft_step || hard_drop) |-> $past(frame_tick));

  // R3
  left_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_left |-> $past(key_left));

  // R3
  right_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_right |-> $past(key_right));

  // R7
  soft_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_step |-> $past(key_soft));

  // R8
  hard_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_drop |-> $past(key_hard));

  // R9
  guard_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_drop |-> !($past(piece_spawn) && $past(dcd_frames) != '0));
endmodule

bind autoshift_ctrl autoshift_ctrl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_tick  (frame_tick),
  .key_left    (key_left),
  .key_right   (key_right),
  .key_soft    (key_soft),
  .key_hard    (key_hard),
  .piece_spawn (piece_spawn),
  .dcd_frames  (dcd_frames),
  .move_left   (move_left),
  .move_right  (move_right),
  .soft_step   (soft_step),
  .hard_drop   (hard_drop)
);

// File: tb/autoshift_ctrl_bench.sv
`timescale 1ns/1ps
module autoshift_ctrl_bench;
  localparam int W  = 8;
  localparam int NV = 35;
  // [8] spawn before frame, [7:4] keys L R S H, [3:0] expected ML MR SS HD
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0000_0000, // 0  idle
    9'b0_1000_1000, // 1  fresh left
    9'b0_1000_0000, // 2
    9'b0_1000_0000, // 3
    9'b0_1000_1000, // 4  first repeat after DAS
    9'b0_1000_0000, // 5
    9'b0_1000_1000, // 6  ARR repeat
    9'b0_1100_0100, // 7  right pressed last wins
    9'b0_1100_0000, // 8
    9'b0_1100_0000, // 9
    9'b0_1100_0100, // 10 right repeat
    9'b0_1000_0000, // 11 handover to left, no move
    9'b0_1000_0000, // 12
    9'b0_1000_0000, // 13
    9'b0_1000_1000, // 14 left after reloaded DAS
    9'b0_0000_0000, // 15
    9'b0_1100_1000, // 16 tie goes left
    9'b0_0000_0000, // 17
    9'b0_0010_0010, // 18 fresh soft
    9'b0_0010_0000, // 19
    9'b0_0010_0010, // 20 soft repeat
    9'b0_0010_0000, // 21
    9'b0_1010_1010, // 22 soft repeat plus fresh left
    9'b0_0000_0000, // 23
    9'b0_0001_0001, // 24 fresh hard
    9'b0_0001_0000, // 25 held hard, no repeat
    9'b0_0000_0000, // 26
    9'b1_0001_0000, // 27 guarded
    9'b0_0000_0000, // 28 guard expiring
    9'b0_0001_0001, // 29 guard over
    9'b0_0000_0000, // 30
    9'b1_0001_0000, // 31 guarded
    9'b0_0001_0000, // 32 held, not deferred
    9'b0_0001_0000, // 33 still held after guard
    9'b0_0000_0000  // 34
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic key_left = 1'b0, key_right = 1'b0, key_soft = 1'b0, key_hard = 1'b0;
  logic piece_spawn = 1'b0;
  logic [W-1:0] das_frames = 8'd3, arr_frames = 8'd2, sdf_frames = 8'd2, dcd_frames = 8'd2;
  logic move_left, move_right, soft_step, hard_drop;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  autoshift_ctrl #(.W(W)) u_autoshift_ctrl (
    .clk, .rst_n, .frame_tick, .key_left, .key_right, .key_soft, .key_hard,
    .piece_spawn, .das_frames, .arr_frames, .sdf_frames, .dcd_frames,
    .move_left, .move_right, .soft_step, .hard_drop
  );

  function automatic logic [3:0] outs();
    return {move_left, move_right, soft_step, hard_drop};
  endfunction

  function automatic string req_of(int i);
    if (i == 0)  return "R1 idle";
    if (i <= 6)  return "R3/R4 left charge and repeat";
    if (i <= 10) return "R5 last press wins";
    if (i <= 14) return "R6 handover";
    if (i <= 17) return "R5 tie";
    if (i <= 23) return "R7 soft drop";
    if (i <= 26) return "R8 hard drop";
    return "R9 hard-drop guard";
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic frame(input logic [3:0] keys, input logic spn,
                       input logic [3:0] exp, input string req);
    if (spn) begin
      @(negedge clk); piece_spawn = 1'b1;
      @(negedge clk); piece_spawn = 1'b0;
    end
    @(negedge clk);
    {key_left, key_right, key_soft, key_hard} = keys;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    chk(req, outs(), exp);
    @(negedge clk);
    chk({req, " R2 pulse width"}, outs(), 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", outs(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][7:4], VEC[i][8], VEC[i][3:0], req_of(i));
    end

    // R4: ARR of 0 repeats every frame, DAS of 1 repeats on the next frame
    das_frames = 8'd1;
    arr_frames = 8'd0;
    frame(4'b0100, 1'b0, 4'b0100, "R4 fresh right");
    for (int k = 0; k < 3; k++) frame(4'b0100, 1'b0, 4'b0100, "R4 ARR zero repeat");
    frame(4'b0000, 1'b0, 4'b0000, "R4 release");

    // R9: DCD of 0 gives no guard
    dcd_frames = 8'd0;
    frame(4'b0001, 1'b1, 4'b0001, "R9 zero guard");
    frame(4'b0000, 1'b0, 4'b0000, "R9 release");

    // R1: key held through reset is a fresh press afterwards
    frame(4'b1000, 1'b0, 4'b1000, "R3 fresh left");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs low in reset", outs(), 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    frame(4'b1000, 1'b0, 4'b1000, "R1 held key fresh after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule